// File: doc/BRIEF.md
# Multi-Field Range Packet Classifier

This block assigns each incoming packet header to a predefined flow by testing six header fields against a small table of rules. The fields are the 32-bit source and destination addresses, the 16-bit source and destination ports, the 8-bit type-of-service byte and the 8-bit protocol number. Every rule holds an inclusive lower and upper bound for each of the six fields. A rule hits only when all six values fall inside its bounds. The rule also carries a flow identifier and an action bit, and the action bit allows access-control rules that refuse a class of traffic.

Headers arrive on a valid/ready handshake, and the block accepts one header every cycle. One cycle after a header is accepted, the block presents a registered flow identifier and a permit/deny action. A per-flow queue stage further down the path uses that flow identifier to pick its queue. When several enabled rules hit, the rule with the lowest index wins. When no rule hits, the result is a programmable default flow with the permit action. The rule table is written one field at a time through a write port.

Top module: `pkt_range_classifier`

## Requirements
- R1: A field lies inside a rule's range when lower bound <= value <= upper bound, with both ends inclusive. A value one below the lower bound or one above the upper bound is outside.
- R2: A rule hits only if all six fields are inside their ranges. One field outside its range is enough to prevent the hit.
- R3: When several enabled rules hit, the result takes its flow and action from the rule with the lowest index.
- R4: A header that hits no enabled rule gets the current default flow identifier and the permit action (res_deny = 0).
- R5: res_deny is 1 exactly when the winning rule has its action bit set to deny.
- R6: res_valid is 1 in the cycle after a header is accepted and 0 otherwise. While res_valid is 0, res_flow and res_deny keep their last values.
- R7: A rule write and a header in the same cycle: that header sees the old table. The first header accepted after the write sees the new table.
- R8: After reset, every rule is disabled, the default flow is 0 and res_valid is 0.
- R9: hdr_ready is 1 in every cycle out of reset.
- R10: Write encoding, with field select codes:
  - Codes 0 to 5 write the bounds of the source address, destination address, source port, destination port, type-of-service and protocol fields, in that order. cfg_wr_lo gives the lower bound and cfg_wr_hi the upper bound, each truncated to the field width.
  - Code 6 writes the rule control word: flow identifier in cfg_wr_lo[FLOW_W-1:0], deny in bit FLOW_W, enable in bit FLOW_W+1.
  - Code 7 writes the default flow from cfg_wr_lo[FLOW_W-1:0], and the rule index is ignored.
  - A disabled rule never hits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hdr_valid | input | 1 | Header tuple present |
| hdr_ready | output | 1 | Header can be accepted |
| hdr_src_addr | input | 32 | Source address |
| hdr_dst_addr | input | 32 | Destination address |
| hdr_src_port | input | 16 | Source port |
| hdr_dst_port | input | 16 | Destination port |
| hdr_tos | input | 8 | Type-of-service byte |
| hdr_proto | input | 8 | Protocol number |
| cfg_wr_en | input | 1 | Table write strobe |
| cfg_wr_idx | input | IDX_W | Rule index to write |
| cfg_wr_field | input | 3 | Field select code (R10) |
| cfg_wr_lo | input | 32 | Lower bound or control/default word |
| cfg_wr_hi | input | 32 | Upper bound |
| res_valid | output | 1 | Classification result present |
| res_flow | output | FLOW_W | Flow identifier |
| res_deny | output | 1 | 1 = deny, 0 = permit |

## Verification
The bench builds the block with its default parameters: eight rules and a 4-bit flow identifier. With eight rules, the bench can step through all 256 enable masks over a set of overlapping rules and check the lowest-index winner for each mask. A second sweep places each of the six fields at one below its lower bound, at each bound, and at one above its upper bound. A further set of checks covers the default path, the deny action, bound truncation and a rule write in the same cycle as a header.

// File: rtl/pkt_cls_pkg.sv
// Shared constants for the range classifier.
// Assumes all header fields fit in a 32-bit bound word.
package pkt_cls_pkg;
    localparam int ADDR_W  = 32;
    localparam int PORT_W  = 16;
    localparam int TOS_W   = 8;
    localparam int PROTO_W = 8;
    localparam int BOUND_W = 32;
    localparam int NF      = 6;

    localparam logic [2:0] FLD_CTRL = 3'd6;
    localparam logic [2:0] FLD_DFLT = 3'd7;

    typedef logic [NF-1:0][BOUND_W-1:0] fld_vec_t;

    // Width mask for field code i (0..5).
    function automatic logic [BOUND_W-1:0] fld_mask(input logic [2:0] i);
        case (i)
            3'd0, 3'd1: fld_mask = {BOUND_W{1'b1}};
            3'd2, 3'd3: fld_mask = BOUND_W'({PORT_W{1'b1}});
            default:    fld_mask = BOUND_W'({TOS_W{1'b1}});
        endcase
    endfunction
endpackage

// File: rtl/range_match.sv
// Inclusive range test: hit when lo <= val <= hi.
// Assumes unsigned operands of equal width.
module range_match #(
    parameter int W = 32
) (
    input  logic [W-1:0] val,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    output logic         hit
);
    // Both bound compares in parallel.
    always_comb hit = (val >= lo) && (val <= hi);
endmodule

// File: rtl/rule_slot.sv
// One classification rule: six range pairs plus flow, deny and enable.
// Assumes header fields arrive zero-extended to BOUND_W bits.
module rule_slot import pkt_cls_pkg::*; #(
    parameter int FLOW_W = 4,
    parameter int IDX_W  = 3,
    parameter int SLOT   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [2:0]        wr_field,
    input  logic [BOUND_W-1:0] wr_lo,
    input  logic [BOUND_W-1:0] wr_hi,
    input  fld_vec_t          fld_val,
    output logic              match,
    output logic [FLOW_W-1:0] flow,
    output logic              deny
);
    fld_vec_t          lo_q, hi_q;
    logic              en_q;
    logic [NF-1:0]     fld_hit;

    // Table storage update for this slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
            en_q <= 1'b0;
            flow <= '0;
            deny <= 1'b0;
        end else if (wr_en && wr_idx == IDX_W'(SLOT)) begin
            if (wr_field < 3'(NF)) begin
                lo_q[wr_field] <= wr_lo & fld_mask(wr_field);
                hi_q[wr_field] <= wr_hi & fld_mask(wr_field);
            end else if (wr_field == FLD_CTRL) begin
                flow <= wr_lo[FLOW_W-1:0];
                deny <= wr_lo[FLOW_W];
                en_q <= wr_lo[FLOW_W+1];
            end
        end
    end

    for (genvar f = 0; f < NF; f++) begin : g_fld
        range_match #(.W(BOUND_W)) u_rm (
            .val(fld_val[f]),
            .lo (lo_q[f]),
            .hi (hi_q[f]),
            .hit(fld_hit[f])
        );
    end

    // Rule hits only when enabled and all fields agree.
    always_comb match = en_q && (&fld_hit);
endmodule

// File: rtl/prio_pick.sv
// Fixed-priority selector: the lowest set request index wins.
// Assumes N >= 2.
module prio_pick #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     gnt,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    // Scan downward so the lowest request is left standing.
    always_comb begin
        gnt = '0;
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
                idx    = IDX_W'(i);
                any    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pkt_range_classifier.sv
// Multi-field range classifier top. Accepts a header every cycle and
// registers flow and action one cycle later. Table writes at an edge
// affect headers accepted from the next edge on.
module pkt_range_classifier import pkt_cls_pkg::*; #(
    parameter int NUM_RULES = 8,
    parameter int FLOW_W    = 4,
    localparam int IDX_W    = $clog2(NUM_RULES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hdr_valid,
    output logic               hdr_ready,
    input  logic [ADDR_W-1:0]  hdr_src_addr,
    input  logic [ADDR_W-1:0]  hdr_dst_addr,
    input  logic [PORT_W-1:0]  hdr_src_port,
    input  logic [PORT_W-1:0]  hdr_dst_port,
    input  logic [TOS_W-1:0]   hdr_tos,
    input  logic [PROTO_W-1:0] hdr_proto,
    input  logic               cfg_wr_en,
    input  logic [IDX_W-1:0]   cfg_wr_idx,
    input  logic [2:0]         cfg_wr_field,
    input  logic [BOUND_W-1:0] cfg_wr_lo,
    input  logic [BOUND_W-1:0] cfg_wr_hi,
    output logic               res_valid,
    output logic [FLOW_W-1:0]  res_flow,
    output logic               res_deny
);
    fld_vec_t                          fld_val;
    logic [NUM_RULES-1:0]              match_vec;
    logic [NUM_RULES-1:0]              grant_vec;
    logic [NUM_RULES-1:0][FLOW_W-1:0]  flow_arr;
    logic [NUM_RULES-1:0]              deny_arr;
    logic [IDX_W-1:0]                  win_idx;
    logic                              win_any;
    logic [FLOW_W-1:0]                 dflt_flow_q;

    // Block never stalls the header source.
    assign hdr_ready = 1'b1;

    // Zero-extend header fields into the common bound width.
    always_comb begin
        fld_val[0] = BOUND_W'(hdr_src_addr);
        fld_val[1] = BOUND_W'(hdr_dst_addr);
        fld_val[2] = BOUND_W'(hdr_src_port);
        fld_val[3] = BOUND_W'(hdr_dst_port);
        fld_val[4] = BOUND_W'(hdr_tos);
        fld_val[5] = BOUND_W'(hdr_proto);
    end

    for (genvar r = 0; r < NUM_RULES; r++) begin : g_rule
        rule_slot #(.FLOW_W(FLOW_W), .IDX_W(IDX_W), .SLOT(r)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (cfg_wr_en),
            .wr_idx  (cfg_wr_idx),
            .wr_field(cfg_wr_field),
            .wr_lo   (cfg_wr_lo),
            .wr_hi   (cfg_wr_hi),
            .fld_val (fld_val),
            .match   (match_vec[r]),
            .flow    (flow_arr[r]),
            .deny    (deny_arr[r])
        );
    end

    prio_pick #(.N(NUM_RULES), .IDX_W(IDX_W)) u_pick (
        .req(match_vec),
        .gnt(grant_vec),
        .idx(win_idx),
        .any(win_any)
    );

    // Default flow register, written with field code 7.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dflt_flow_q <= '0;
        else if (cfg_wr_en && cfg_wr_field == FLD_DFLT)
            dflt_flow_q <= cfg_wr_lo[FLOW_W-1:0];
    end

    // Result register: capture on accept, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_flow  <= '0;
            res_deny  <= 1'b0;
        end else begin
            res_valid <= hdr_valid;
            if (hdr_valid) begin
                res_flow <= win_any ? flow_arr[win_idx] : dflt_flow_q;
                res_deny <= win_any && deny_arr[win_idx];
            end
        end
    end
endmodule

// File: rtl/pkt_range_classifier_chk.sv
// Property checker for the classifier, attached by bind.
// Observes ports plus the match, grant and default signals.
module pkt_range_classifier_chk #(
    parameter int NUM_RULES = 8,
    parameter int FLOW_W    = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 hdr_valid,
    input logic                 hdr_ready,
    input logic                 res_valid,
    input logic [FLOW_W-1:0]    res_flow,
    input logic                 res_deny,
    input logic [NUM_RULES-1:0] match_vec,
    input logic [NUM_RULES-1:0] grant_vec,
    input logic [FLOW_W-1:0]    dflt_flow_q
);
    assert_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_ready);

    assert_valid_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |=> res_valid);

    assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_valid |=> !res_valid);

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_valid |=> ($stable(res_flow) && $stable(res_deny)));

    assert_grant_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_vec));

    assert_grant_in_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vec & ~match_vec) == '0);

    assert_grant_lowest_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vec != '0) |-> ((match_vec & (grant_vec - 1'b1)) == '0));

    assert_grant_when_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (match_vec != '0) |-> (grant_vec != '0));

    assert_default_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && match_vec == '0) |=>
            (res_flow == $past(dflt_flow_q) && !res_deny));

    assert_reset_R8: assert property (@(posedge clk)
        !rst_n |=> !res_valid);
endmodule

bind pkt_range_classifier pkt_range_classifier_chk #(
    .NUM_RULES(NUM_RULES),
    .FLOW_W   (FLOW_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hdr_valid  (hdr_valid),
    .hdr_ready  (hdr_ready),
    .res_valid  (res_valid),
    .res_flow   (res_flow),
    .res_deny   (res_deny),
    .match_vec  (match_vec),
    .grant_vec  (grant_vec),
    .dflt_flow_q(dflt_flow_q)
);

// File: tb/tb_pkt_range_classifier.sv
`timescale 1ns/1ps
module tb_pkt_range_classifier;
    localparam int NR = 8;
    localparam int FW = 4;
    localparam int IW = $clog2(NR);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hdr_valid = 1'b0;
    logic          hdr_ready;
    logic [31:0]   hdr_src_addr = '0, hdr_dst_addr = '0;
    logic [15:0]   hdr_src_port = '0, hdr_dst_port = '0;
    logic [7:0]    hdr_tos = '0, hdr_proto = '0;
    logic          cfg_wr_en = 1'b0;
    logic [IW-1:0] cfg_wr_idx = '0;
    logic [2:0]    cfg_wr_field = '0;
    logic [31:0]   cfg_wr_lo = '0, cfg_wr_hi = '0;
    logic          res_valid;
    logic [FW-1:0] res_flow;
    logic          res_deny;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pkt_range_classifier #(.NUM_RULES(NR), .FLOW_W(FW)) dut (
        .clk(clk), .rst_n(rst_n),
        .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
        .hdr_src_addr(hdr_src_addr), .hdr_dst_addr(hdr_dst_addr),
        .hdr_src_port(hdr_src_port), .hdr_dst_port(hdr_dst_port),
        .hdr_tos(hdr_tos), .hdr_proto(hdr_proto),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_idx(cfg_wr_idx),
        .cfg_wr_field(cfg_wr_field), .cfg_wr_lo(cfg_wr_lo), .cfg_wr_hi(cfg_wr_hi),
        .res_valid(res_valid), .res_flow(res_flow), .res_deny(res_deny)
    );

    // Bench-side rule model.
    logic [31:0]   m_lo [NR][6];
    logic [31:0]   m_hi [NR][6];
    logic [FW-1:0] m_flow [NR];
    logic          m_deny [NR];
    logic          m_en [NR];
    logic [FW-1:0] m_dflt;

    function automatic logic [31:0] wmask(input int f);
        if (f < 2) return 32'hFFFF_FFFF;
        if (f < 4) return 32'h0000_FFFF;
        return 32'h0000_00FF;
    endfunction

    // Returns {deny, flow} expected for header values v.
    function automatic logic [FW:0] model(input logic [5:0][31:0] v);
        for (int r = 0; r < NR; r++) begin
            bit ok = m_en[r];
            for (int f = 0; f < 6; f++)
                if (v[f] < m_lo[r][f] || v[f] > m_hi[r][f]) ok = 1'b0;
            if (ok) return {m_deny[r], m_flow[r]};
        end
        return {1'b0, m_dflt};
    endfunction

    task automatic check_val(input string req, input string what,
                             input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input int idx, input logic [2:0] fld,
                             input logic [31:0] lo, input logic [31:0] hi);
        cfg_wr_en = 1'b1; cfg_wr_idx = IW'(idx); cfg_wr_field = fld;
        cfg_wr_lo = lo; cfg_wr_hi = hi;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        if (fld < 3'd6) begin
            m_lo[idx][fld] = lo & wmask(int'(fld));
            m_hi[idx][fld] = hi & wmask(int'(fld));
        end else if (fld == 3'd6) begin
            m_flow[idx] = lo[FW-1:0]; m_deny[idx] = lo[FW]; m_en[idx] = lo[FW+1];
        end else begin
            m_dflt = lo[FW-1:0];
        end
    endtask

    task automatic set_hdr(input logic [5:0][31:0] v);
        hdr_src_addr = v[0]; hdr_dst_addr = v[1];
        hdr_src_port = v[2][15:0]; hdr_dst_port = v[3][15:0];
        hdr_tos = v[4][7:0]; hdr_proto = v[5][7:0];
    endtask

    task automatic send_check(input logic [5:0][31:0] v, input string req);
        logic [FW:0] e;
        e = model(v);
        set_hdr(v);
        hdr_valid = 1'b1;
        @(negedge clk);
        hdr_valid = 1'b0;
        check_val(req, "res_valid", 32'(res_valid), 32'd1);
        check_val(req, "res_flow", 32'(res_flow), 32'(e[FW-1:0]));
        check_val(req, "res_deny", 32'(res_deny), 32'(e[FW]));
    endtask

    function automatic logic [31:0] ctrl(input int flow, input bit deny, input bit en);
        return 32'(flow) | (32'(deny) << FW) | (32'(en) << (FW + 1));
    endfunction

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [5:0][31:0] v;
        logic [5:0][31:0] mid;
        logic [31:0] lo2 [6];
        logic [31:0] hi2 [6];
        logic [FW-1:0] held;

        for (int r = 0; r < NR; r++) begin
            m_en[r] = 1'b0; m_deny[r] = 1'b0; m_flow[r] = '0;
            for (int f = 0; f < 6; f++) begin m_lo[r][f] = '0; m_hi[r][f] = '0; end
        end
        m_dflt = '0;

        repeat (3) @(negedge clk);
        // R8: outputs in reset
        check_val("R8", "res_valid in reset", 32'(res_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check_val("R8", "res_valid after reset", 32'(res_valid), 32'd0);
        check_val("R9", "hdr_ready", 32'(hdr_ready), 32'd1);
        // R8/R10: all-zero header, no enabled rule, default 0
        send_check('0, "R8");

        // R10/R4: program default flow, no rule enabled
        cfg_write(5, 3'd7, 32'hF, 32'h0);
        v = {32'd17, 32'd0, 32'd99, 32'd443, 32'hC0A8_0101, 32'h0A00_0001};
        send_check(v, "R4");

        // Rule 2 bounds (field order R10: src, dst, sport, dport, tos, proto)
        lo2 = '{32'h0A00_0000, 32'hC0A8_0100, 32'd1000, 32'd80, 32'h10, 32'd6};
        hi2 = '{32'h0A00_00FF, 32'hC0A8_013F, 32'd2000, 32'd80, 32'h1F, 32'd6};
        for (int f = 0; f < 6; f++) cfg_write(2, 3'(f), lo2[f], hi2[f]);
        cfg_write(2, 3'd6, ctrl(5, 1'b0, 1'b1), 32'h0);
        for (int f = 0; f < 6; f++) mid[f] = lo2[f] + ((hi2[f] - lo2[f]) >> 1);
        send_check(mid, "R2");

        // R1/R2: boundary sweep per field with others inside
        for (int f = 0; f < 6; f++) begin
            for (int p = 0; p < 4; p++) begin
                v = mid;
                case (p)
                    0: v[f] = lo2[f] - 1;
                    1: v[f] = lo2[f];
                    2: v[f] = hi2[f];
                    default: v[f] = hi2[f] + 1;
                endcase
                send_check(v, (p == 1 || p == 2) ? "R1" : "R2");
            end
        end

        // R5/R3: nested deny rule 1 inside rule 2
        cfg_write(1, 3'd0, 32'h0A00_0010, 32'h0A00_0020);
        for (int f = 1; f < 6; f++) cfg_write(1, 3'(f), lo2[f], hi2[f]);
        cfg_write(1, 3'd6, ctrl(9, 1'b1, 1'b1), 32'h0);
        v = mid; v[0] = 32'h0A00_0015;
        send_check(v, "R5");
        check_val("R5", "deny set", 32'(res_deny), 32'd1);
        v[0] = 32'h0A00_0021;
        send_check(v, "R3");

        // R7: write in same cycle as header sees old table
        v = mid; v[0] = 32'h0A00_0030;
        cfg_wr_en = 1'b1; cfg_wr_idx = IW'(2); cfg_wr_field = 3'd6;
        cfg_wr_lo = ctrl(5, 1'b0, 1'b0); cfg_wr_hi = '0;
        set_hdr(v); hdr_valid = 1'b1;
        @(negedge clk);
        cfg_wr_en = 1'b0; hdr_valid = 1'b0;
        check_val("R7", "old-table flow", 32'(res_flow), 32'd5);
        m_en[2] = 1'b0;
        send_check(v, "R7");
        check_val("R7", "new-table flow", 32'(res_flow), 32'hF);

        // R6: idle cycle drops valid and holds result
        held = res_flow;
        v = '0; set_hdr(v);
        @(negedge clk);
        check_val("R6", "res_valid idle", 32'(res_valid), 32'd0);
        check_val("R6", "res_flow held", 32'(res_flow), 32'(held));

        // R10: bounds truncated to field width (dport)
        for (int f = 0; f < 6; f++)
            if (f == 3) cfg_write(3, 3'd3, 32'h0001_0050, 32'h0001_0050);
            else cfg_write(3, 3'(f), 32'h0, 32'hFFFF_FFFF);
        cfg_write(3, 3'd6, ctrl(7, 1'b0, 1'b1), 32'h0);
        v = {32'd1, 32'd2, 32'd80, 32'd3, 32'h1, 32'h2};
        send_check(v, "R10");
        check_val("R10", "truncated hit", 32'(res_flow), 32'd7);
        v[3] = 32'd81;
        send_check(v, "R10");

        // R3: exhaustive enable-mask sweep over eight full-range rules
        for (int r = 0; r < NR; r++)
            for (int f = 0; f < 6; f++) cfg_write(r, 3'(f), 32'h0, 32'hFFFF_FFFF);
        cfg_write(0, 3'd7, 32'h0, 32'h0);
        v = {32'd8, 32'd7, 32'd600, 32'd500, 32'h0A00_0002, 32'h0A00_0001};
        for (int m = 0; m < 256; m++) begin
            for (int r = 0; r < NR; r++)
                cfg_write(r, 3'd6, ctrl(r + 1, r[0], m[r]), 32'h0);
            send_check(v, "R3");
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule